// File: doc/BRIEF.md
# Byte ALU with Chained Flags

This block is an 8-bit arithmetic and logic unit. Each cycle it takes operand A and a second operand, which is either a register value or an immediate constant. It forms a result byte at once, without a clock edge. On the following clock edge it updates a five-flag status register.

The stored carry and zero flags feed back into the next operation. Software can therefore build a 16-bit or 32-bit subtraction or comparison from a run of byte operations, starting with the least significant byte. The first byte uses a plain subtract or compare. Each later byte uses the with-carry form. In the with-carry form the zero flag can only stay high if it was already high, so after the top byte the zero flag reports equality of the whole wide value. The negative and overflow flags come from the top byte alone, and that byte is processed last.

Compare operations produce flags but signal that their result must not be written back. Single-operand operations (complement, negate) and a flag-neutral move also pass through the unit.

Top module: `byte_alu_chain`

## Requirements
- R1: Opcode 0 (add) gives result = A + B modulo 256. Carry is set when the unsigned sum exceeds 255, zero is set when the result is 0, and overflow is set on signed overflow of the 8-bit sum.
- R2: Opcode 2 (subtract) and opcode 4 (compare) give A − B modulo 256. Carry is set when A < B unsigned. The zero flag depends only on whether this byte's result is 0, whatever the earlier zero flag was.
- R3: Opcode 3 (subtract with carry) gives A − B − C_old modulo 256, where C_old is the stored carry. The new carry is the borrow, set when A < B + C_old.
- R4: For opcodes 3 and 5, the new zero flag is high only if the current result is 0 and the stored zero flag was high. After a plain subtract or compare on the low byte and with-carry operations on the higher bytes, zero is high exactly when the wide operands are equal.
- R5: Opcode 5 (compare with carry) sets the same flags as opcode 3. For opcodes 4 and 5, `resultValid` is low. For every other defined opcode (0–11), `resultValid` is high.
- R6: After an arithmetic operation, negative equals bit 7 of the result and overflow is the signed overflow of that byte alone. At the end of a chain they therefore describe the whole wide value.
- R7: The sign flag always equals negative XOR overflow.
- R8: Opcodes 6, 7 and 8 (AND, OR, XOR) clear overflow and leave carry unchanged. They set zero and negative from their own result only.
- R9: The flags change only on a clock edge where `flagWe` is high. When `flagWe` is low, all flags hold.
- R10: When `useImm` is high, the second operand is `immVal`; otherwise it is `regB`. Opcode 11 (move) outputs the second operand and leaves all flags unchanged.
- R11: During reset, all five flags are 0.
- R12: Opcode 9 (complement) gives ~A with carry = 1 and overflow = 0. Opcode 10 (negate) gives 0 − A with carry = (A ≠ 0) and overflow = (A = 0x80).
- R13: Opcode 1 (add with carry) gives A + B + C_old modulo 256. Carry and overflow follow from the full sum.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| opA | input | 8 | First operand |
| regB | input | 8 | Second operand from a register |
| immVal | input | 8 | Second operand as an immediate constant |
| useImm | input | 1 | Select `immVal` as the second operand |
| opCode | input | 4 | Operation code (0–11 defined) |
| flagWe | input | 1 | Status register write enable |
| result | output | 8 | Result byte (combinational) |
| resultValid | output | 1 | Result should be written back |
| cFlag | output | 1 | Carry / borrow flag |
| zFlag | output | 1 | Zero flag |
| nFlag | output | 1 | Negative flag |
| vFlag | output | 1 | Two's-complement overflow flag |
| sFlag | output | 1 | Sign flag (negative XOR overflow) |

## Verification
The bench runs 32-bit subtract and compare chains and checks them against a wide reference model. The cases are: fully equal operands; operands that differ only in the low byte; and operands that share a zero-difference top byte but differ lower down. A unit that took zero from the last byte alone would report a false "equal" in the last two cases. A unit that ignored the stored borrow would give a wrong high byte and a wrong carry after a low-byte borrow. Single-byte checks target the ends of each range:
- add overflow at 0x7F + 1;
- negate of 0 and of 0x80;
- carry preserved across logic operations;
- flags frozen while the write enable is low.

A design that mixed up any of these would show a wrong flag one cycle after the operation.

// File: rtl/alu_chain_pkg.sv
package alu_chain_pkg;

  localparam int OPC_W = 4;

  typedef enum logic [OPC_W-1:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBC  = 4'd3,
    OP_CMP  = 4'd4,
    OP_CPC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_COM  = 4'd9,
    OP_NEG  = 4'd10,
    OP_PASS = 4'd11
  } aluOp_e;

  typedef enum logic [2:0] {
    K_ARITH,
    K_LOGIC,
    K_COM,
    K_NEG,
    K_PASS
  } aluKind_e;

  typedef enum logic [1:0] {
    L_AND,
    L_OR,
    L_XOR
  } logicFn_e;

  // strobes from control to datapath
  typedef struct packed {
    aluKind_e kind;
    logicFn_e logicFn;
    logic     subtract;
    logic     useCarryIn;
    logic     chainZero;
    logic     writeBack;
    logic     flagAllow;
  } aluStrobe_t;

  typedef struct packed {
    logic c;
    logic z;
    logic n;
    logic v;
    logic s;
  } aluFlags_t;

endpackage

// File: rtl/alu_chain_ctrl.sv
module alu_chain_ctrl
  import alu_chain_pkg::*;
(
  input  logic [OPC_W-1:0] opCode,
  output aluStrobe_t       str
);

  always_comb begin
    str            = '0;
    str.kind       = K_PASS;
    str.logicFn    = L_AND;
    str.writeBack  = 1'b1;
    str.flagAllow  = 1'b1;
    case (opCode)
      OP_ADD: str.kind = K_ARITH;
      OP_ADC: begin
        str.kind       = K_ARITH;
        str.useCarryIn = 1'b1;
      end
      OP_SUB: begin
        str.kind     = K_ARITH;
        str.subtract = 1'b1;
      end
      OP_SBC: begin
        str.kind       = K_ARITH;
        str.subtract   = 1'b1;
        str.useCarryIn = 1'b1;
        str.chainZero  = 1'b1;
      end
      OP_CMP: begin
        str.kind      = K_ARITH;
        str.subtract  = 1'b1;
        str.writeBack = 1'b0;
      end
      OP_CPC: begin
        str.kind       = K_ARITH;
        str.subtract   = 1'b1;
        str.useCarryIn = 1'b1;
        str.chainZero  = 1'b1;
        str.writeBack  = 1'b0;
      end
      OP_AND: begin
        str.kind    = K_LOGIC;
        str.logicFn = L_AND;
      end
      OP_OR: begin
        str.kind    = K_LOGIC;
        str.logicFn = L_OR;
      end
      OP_XOR: begin
        str.kind    = K_LOGIC;
        str.logicFn = L_XOR;
      end
      OP_COM:  str.kind = K_COM;
      OP_NEG:  str.kind = K_NEG;
      OP_PASS: str.flagAllow = 1'b0;
      default: begin
        str.writeBack = 1'b0;
        str.flagAllow = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/alu_chain_datapath.sv
module alu_chain_datapath
  import alu_chain_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] immVal,
  input  logic              useImm,
  input  logic              flagWe,
  input  aluStrobe_t        str,
  output logic [DATA_W-1:0] result,
  output aluFlags_t         flags
);

  localparam int MSB = DATA_W - 1;
  localparam logic [DATA_W-1:0] MIN_NEG = {1'b1, {MSB{1'b0}}};

  logic [DATA_W-1:0] bSel;
  logic [DATA_W-1:0] bOp;
  logic              carryIn;
  logic [DATA_W:0]   sum;
  logic              arithC;
  logic              arithV;
  logic [DATA_W-1:0] logicRes;
  logic              zCur;
  aluFlags_t         flagsNext;

  // second operand and adder input
  always_comb begin
    bSel = useImm ? immVal : regB;
    bOp  = str.subtract ? ~bSel : bSel;
    if (str.useCarryIn)
      carryIn = str.subtract ? ~flags.c : flags.c;
    else
      carryIn = str.subtract;
    sum    = {1'b0, opA} + {1'b0, bOp} + {{DATA_W{1'b0}}, carryIn};
    arithC = str.subtract ? ~sum[DATA_W] : sum[DATA_W];
    arithV = (opA[MSB] == bOp[MSB]) && (sum[MSB] != opA[MSB]);
  end

  always_comb begin
    case (str.logicFn)
      L_OR:    logicRes = opA | bSel;
      L_XOR:   logicRes = opA ^ bSel;
      default: logicRes = opA & bSel;
    endcase
  end

  // result mux and next flags
  always_comb begin
    flagsNext = flags;
    case (str.kind)
      K_ARITH: begin
        result      = sum[MSB:0];
        flagsNext.c = arithC;
        flagsNext.v = arithV;
      end
      K_LOGIC: begin
        result      = logicRes;
        flagsNext.v = 1'b0;
      end
      K_COM: begin
        result      = ~opA;
        flagsNext.c = 1'b1;
        flagsNext.v = 1'b0;
      end
      K_NEG: begin
        result      = {DATA_W{1'b0}} - opA;
        flagsNext.c = (opA != '0);
        flagsNext.v = (opA == MIN_NEG);
      end
      default: result = bSel;
    endcase
    zCur        = (result == '0);
    flagsNext.z = str.chainZero ? (zCur & flags.z) : zCur;
    flagsNext.n = result[MSB];
    flagsNext.s = flagsNext.n ^ flagsNext.v;
  end

  // status register
  always_ff @(posedge clk) begin
    if (!rstN)
      flags <= '0;
    else if (flagWe && str.flagAllow)
      flags <= flagsNext;
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !flagWe |=> $stable(flags));

  p_logic_clear_v_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && str.flagAllow && str.kind == K_LOGIC) |=> !flags.v);

  p_logic_keep_c_r8: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && str.flagAllow && str.kind == K_LOGIC) |=> flags.c == $past(flags.c));

  p_chain_zero_r4: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && str.flagAllow && str.chainZero && !flags.z) |=> !flags.z);

  p_neg_zero_r12: assert property (@(posedge clk) disable iff (!rstN)
    (flagWe && str.flagAllow && str.kind == K_NEG && opA == '0) |=> (!flags.c && flags.z));

endmodule

// File: rtl/byte_alu_chain.sv
module byte_alu_chain
  import alu_chain_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] regB,
  input  logic [DATA_W-1:0] immVal,
  input  logic              useImm,
  input  logic [OPC_W-1:0]  opCode,
  input  logic              flagWe,
  output logic [DATA_W-1:0] result,
  output logic              resultValid,
  output logic              cFlag,
  output logic              zFlag,
  output logic              nFlag,
  output logic              vFlag,
  output logic              sFlag
);

  aluStrobe_t str;
  aluFlags_t  flags;

  alu_chain_ctrl i_ctrl (
    .opCode (opCode),
    .str    (str)
  );

  alu_chain_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk    (clk),
    .rstN   (rstN),
    .opA    (opA),
    .regB   (regB),
    .immVal (immVal),
    .useImm (useImm),
    .flagWe (flagWe),
    .str    (str),
    .result (result),
    .flags  (flags)
  );

  assign resultValid = str.writeBack;
  assign cFlag = flags.c;
  assign zFlag = flags.z;
  assign nFlag = flags.n;
  assign vFlag = flags.v;
  assign sFlag = flags.s;

  p_cmp_nowrite_r5: assert property (@(posedge clk) disable iff (!rstN)
    (opCode == OP_CMP || opCode == OP_CPC) |-> !resultValid);

endmodule

// File: tb/test_byte_alu_chain.sv
module test_byte_alu_chain;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [7:0] opA = '0, regB = '0, immVal = '0;
  logic       useImm = 1'b0;
  logic [3:0] opCode = '0;
  logic       flagWe = 1'b0;
  logic [7:0] result;
  logic       resultValid, cFlag, zFlag, nFlag, vFlag, sFlag;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  // bench model of the stored flags
  bit mC, mZ, mN, mV, mS;

  always #2 clk = ~clk;

  byte_alu_chain i_byte_alu_chain (
    .clk(clk), .rstN(rstN), .opA(opA), .regB(regB), .immVal(immVal),
    .useImm(useImm), .opCode(opCode), .flagWe(flagWe), .result(result),
    .resultValid(resultValid), .cFlag(cFlag), .zFlag(zFlag), .nFlag(nFlag),
    .vFlag(vFlag), .sFlag(sFlag)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic checkFlags(input string req);
    check({req, " flags CZNVS"}, {cFlag, zFlag, nFlag, vFlag, sFlag},
          {mC, mZ, mN, mV, mS});
  endtask

  // drive one operation, check result, clock it, check flags
  task automatic apply(input string req, input int op, input logic [7:0] a,
                       input logic [7:0] b, input logic imm, input logic we);
    int ai, bi, sa, sb, ci, full, sfull;
    logic [7:0] r;
    bit c, z, v, upd, valid;
    ai = a; bi = b; sa = $signed(a); sb = $signed(b);
    c = mC; z = mZ; v = mV; upd = 1'b1; valid = 1'b1; r = '0;
    case (op)
      0, 1: begin
        ci = (op == 1) ? int'(mC) : 0;
        full = ai + bi + ci; sfull = sa + sb + ci;
        r = full[7:0]; c = full > 255; v = sfull > 127 || sfull < -128;
        z = r == 0;
      end
      2, 3, 4, 5: begin
        ci = (op == 3 || op == 5) ? int'(mC) : 0;
        full = ai - bi - ci; sfull = sa - sb - ci;
        r = full[7:0]; c = full < 0; v = sfull > 127 || sfull < -128;
        z = (r == 0) && ((op == 3 || op == 5) ? mZ : 1'b1);
        valid = !(op == 4 || op == 5);
      end
      6, 7, 8: begin
        r = (op == 6) ? (a & b) : (op == 7) ? (a | b) : (a ^ b);
        v = 1'b0; z = r == 0;
      end
      9:  begin r = ~a; c = 1'b1; v = 1'b0; z = r == 0; end
      10: begin r = 8'(0 - ai); c = a != 0; v = a == 8'h80; z = r == 0; end
      default: begin r = b; upd = 1'b0; end
    endcase
    @(negedge clk);
    opCode = 4'(op); opA = a; useImm = imm; flagWe = we;
    if (imm) begin immVal = b; regB = ~b; end
    else begin regB = b; immVal = ~b; end
    #1;
    check({req, " result"}, result, r);
    check({req, " resultValid"}, resultValid, valid);
    @(posedge clk); #1;
    if (we && upd) begin
      mC = c; mZ = z; mN = r[7]; mV = v; mS = r[7] ^ v;
    end
    checkFlags(req);
    flagWe = 1'b0;
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(posedge clk);
    #1;
    mC = 0; mZ = 0; mN = 0; mV = 0; mS = 0;
    checkFlags("R11 reset");
    @(negedge clk); rstN = 1'b1;
  endtask

  task automatic tAdd();
    apply("R1 add plain", 0, 8'h12, 8'h34, 0, 1);
    apply("R1 add overflow 7F+1", 0, 8'h7F, 8'h01, 0, 1);
    apply("R1 add carry to zero", 0, 8'hFF, 8'h01, 0, 1);
    apply("R13 adc with carry", 1, 8'h10, 8'h20, 0, 1);
    apply("R13 adc carry out", 1, 8'h80, 8'h80, 0, 1);
    apply("R7 sign after adc", 1, 8'hC0, 8'h10, 0, 1);
  endtask

  task automatic tSub();
    apply("R2 prep zero low", 0, 8'h01, 8'h01, 0, 1);
    apply("R2 sub zero alone", 2, 8'h44, 8'h44, 0, 1);
    apply("R2 sub borrow", 2, 8'h01, 8'h02, 0, 1);
    apply("R3 sbc uses borrow", 3, 8'h10, 8'h05, 0, 1);
    apply("R6 sub signed overflow", 2, 8'h80, 8'h01, 0, 1);
    apply("R2 cmp imm", 4, 8'h30, 8'h30, 1, 1);
  endtask

  task automatic tLogic();
    apply("R8 prep carry", 2, 8'h00, 8'h01, 0, 1);
    apply("R8 and keeps carry", 6, 8'hF0, 8'h0F, 0, 1);
    apply("R8 or", 7, 8'h80, 8'h01, 0, 1);
    apply("R8 xor", 8, 8'hAA, 8'h55, 1, 1);
    apply("R12 com", 9, 8'h00, 8'h00, 0, 1);
    apply("R12 neg zero", 10, 8'h00, 8'h00, 0, 1);
    apply("R12 neg 80", 10, 8'h80, 8'h00, 0, 1);
    apply("R12 neg 01", 10, 8'h01, 8'h00, 0, 1);
  endtask

  task automatic tHold();
    apply("R9 prep", 2, 8'h00, 8'h01, 0, 1);
    apply("R9 no write add", 0, 8'h00, 8'h00, 0, 0);
    apply("R9 no write neg", 10, 8'h80, 8'h00, 0, 0);
    apply("R10 imm select", 0, 8'h01, 8'h02, 1, 1);
    apply("R10 pass reg", 11, 8'h00, 8'h00, 0, 1);
    apply("R10 pass imm", 11, 8'h33, 8'hC3, 1, 1);
  endtask

  // 32-bit chain: byte 0 plain, bytes 1..3 with carry
  task automatic tWide(input string req, input logic [31:0] wa,
                       input logic [31:0] wb, input bit useCmp);
    longint d;
    longint sd;
    bit expN, expV;
    apply({req, " byte0"}, useCmp ? 4 : 2, wa[7:0], wb[7:0], 0, 1);
    for (int i = 1; i < 4; i++)
      apply({req, " byteN"}, useCmp ? 5 : 3, wa[8*i +: 8], wb[8*i +: 8], 0, 1);
    d = longint'(wa) - longint'(wb);
    sd = longint'($signed(wa)) - longint'($signed(wb));
    expN = d[31];
    expV = sd > 64'sd2147483647 || sd < -64'sd2147483648;
    check({req, " R4 wide zero"}, zFlag, wa == wb);
    check({req, " R3 wide borrow"}, cFlag, wa < wb);
    check({req, " R6 wide neg"}, nFlag, expN);
    check({req, " R6 wide ovf"}, vFlag, expV);
    check({req, " R7 wide sign"}, sFlag, expN ^ expV);
  endtask

  task automatic tChains();
    tWide("R4 equal", 32'h1234_5678, 32'h1234_5678, 0);
    tWide("R4 low byte differs", 32'h1234_5679, 32'h1234_5678, 0);
    tWide("R4 high byte equal", 32'h7700_0000, 32'h7701_0000, 0);
    tWide("R5 cpc equal", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 1);
    tWide("R5 cpc low differs", 32'h0000_0001, 32'h0000_0000, 1);
    tWide("R6 signed wide ovf", 32'h8000_0000, 32'h0000_0001, 1);
    tWide("R3 borrow ripple", 32'h0100_0000, 32'h0000_0001, 0);
  endtask

  initial begin
    tReset();
    tAdd();
    tSub();
    tLogic();
    tHold();
    tChains();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule